// File: doc/BRIEF.md
# Trunk Group Load-Sharing Port Masker

This block produces the egress port set for one frame in a switch whose physical ports may be bundled into trunk groups. A lookup stage upstream supplies the VLAN membership of the frame, the ingress port number, both MAC addresses and the trunk group recorded for the learned source address. The block derives a small hash key from the addresses. It uses the key to pick one of several software-written forwarding masks. Each mask leaves exactly one member of every trunk group open, and the chosen mask is combined with the VLAN membership. Every port in the ingress trunk is then removed, so that a frame never goes back into the bundle it arrived on.

Software sets up two register sets through a single write port: the forwarding masks, one per key value, and a per-port trunk group number. The block also compares the learned trunk group of the source station with the group of the ingress port. When that comparison is enabled, a mismatch is reported as a station move. Each result is registered and appears with a valid pulse one cycle after the input strobe.

Top module: `trunk_port_masker`

## Requirements
- R1: After reset `out_valid`, `out_mask` and `out_moved` are 0. Every forwarding mask resets to all ones, and every port's group number resets to 0, so a frame sent before any configuration leaves with its VLAN mask unchanged.
- R2: The hash key is the XOR of bits [2:0] of `in_dst_mac` and bits [2:0] of `in_src_mac`. It selects forwarding mask entry 0 to 7.
- R3: `out_mask` is the VLAN mask ANDed with the selected forwarding mask, with the exclusion of R4 then applied. Bit i stands for port i: ports 0 to 11 are the fast ports and port 12 is the gigabit port.
- R4: When the ingress port's group number is nonzero, every port holding that same number is cleared in `out_mask`. Group number 0 means "not trunked" and never causes an exclusion.
- R5: `out_moved` is 1 only when `move_chk_en` is 1 and `in_learned_gid` differs from the ingress port's group number. With `move_chk_en` at 0 it is always 0.
- R6: `out_valid` is 1 for exactly one cycle, the cycle after a cycle with `in_valid` at 1. While `in_valid` is 0, `out_mask` and `out_moved` hold their values.
- R7: A write with `cfg_we`=1 and `cfg_target`=0 loads `cfg_wdata` into forwarding mask entry `cfg_addr`. Addresses 8 to 15 change no entry.
- R8: A write with `cfg_we`=1 and `cfg_target`=1 loads `cfg_wdata[2:0]` as the group number of port `cfg_addr`. Addresses 13 to 15 change no port.
- R9: A frame presented in the same cycle as a configuration write is processed with the register contents from before the write. The next frame sees the new contents.
- R10: An ingress port number of 13 or more is treated as group 0: nothing is excluded, and the move check compares against 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_target | input | 1 | 0 = forwarding mask entry, 1 = port group number |
| cfg_addr | input | 4 | Mask entry index or port number |
| cfg_wdata | input | 13 | Mask bits, or group number in [2:0] |
| move_chk_en | input | 1 | Enables the station-move comparison |
| in_valid | input | 1 | Frame strobe |
| in_src_port | input | 4 | Ingress port number |
| in_vlan_mask | input | 13 | VLAN member ports |
| in_dst_mac | input | 48 | Destination MAC address |
| in_src_mac | input | 48 | Source MAC address |
| in_learned_gid | input | 3 | Trunk group stored for the learned source address |
| out_valid | output | 1 | Result strobe |
| out_mask | output | 13 | Final egress port mask |
| out_moved | output | 1 | Station-move indication |

## Verification
The configuration path and the frame path can act in the same clock cycle. A new mask entry, or a new group number, may then be written while a frame that selects that very entry or port is being evaluated. The bench provokes this by driving a write to the entry addressed by a frame's key in the same cycle as the frame strobe. It expects the pre-write result for that frame, and then sends the same frame again and expects the post-write result. A group-number rewrite of the ingress port is collided with a frame in the same way. There the bench judges the exclusion set and the move flag, which must both still follow the old group.

// File: rtl/trunk_pkg.sv
package trunk_pkg;

   // Selects which register set a configuration write lands in
   typedef enum logic {
      CFG_FWD_MASK = 1'b0,
      CFG_GROUP_ID = 1'b1
   } cfg_target_e;

   // Hash variants selectable through the HASH_MODE parameter
   localparam int HASH_XOR_BOTH = 0;
   localparam int HASH_SRC_ONLY = 1;

endpackage

// File: rtl/tpm_hash.sv
module tpm_hash #(
   parameter int MAC_W     = 48,
   parameter int KEY_W     = 3,
   parameter int HASH_MODE = 0
) (
   input  logic [MAC_W-1:0] dst_mac,
   input  logic [MAC_W-1:0] src_mac,
   output logic [KEY_W-1:0] key
);
   import trunk_pkg::*;

   if (KEY_W < 1 || KEY_W >= MAC_W) begin : g_bad_key
      $error("tpm_hash: KEY_W out of range");
   end

   if (HASH_MODE == HASH_XOR_BOTH) begin : g_xor
      logic unused_hi_bits;
      assign key            = dst_mac[KEY_W-1:0] ^ src_mac[KEY_W-1:0];
      assign unused_hi_bits = ^{dst_mac[MAC_W-1:KEY_W], src_mac[MAC_W-1:KEY_W]};
   end else if (HASH_MODE == HASH_SRC_ONLY) begin : g_src
      logic unused_hi_bits;
      assign key            = src_mac[KEY_W-1:0];
      assign unused_hi_bits = ^{dst_mac, src_mac[MAC_W-1:KEY_W]};
   end else begin : g_bad_mode
      $error("tpm_hash: unknown HASH_MODE");
   end

endmodule

// File: rtl/tpm_mask_bank.sv
module tpm_mask_bank #(
   parameter int NUM_PORTS = 13,
   parameter int KEY_W     = 3,
   parameter int ADDR_W    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [NUM_PORTS-1:0] wr_data,
   input  logic [KEY_W-1:0]     rd_key,
   output logic [NUM_PORTS-1:0] rd_mask
);
   localparam int NUM_KEYS = 1 << KEY_W;

   if (ADDR_W < KEY_W) begin : g_bad_addr
      $error("tpm_mask_bank: address too narrow for key range");
   end

   logic [NUM_KEYS-1:0][NUM_PORTS-1:0] entry_q;

   for (genvar k = 0; k < NUM_KEYS; k++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            entry_q[k] <= '1;
         end else if (wr_en && (wr_addr == ADDR_W'(k))) begin
            entry_q[k] <= wr_data;
         end
      end
   end

   assign rd_mask = entry_q[rd_key];

   // R7
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(entry_q))
      else $error("mask bank changed without a write");

endmodule

// File: rtl/tpm_group_file.sv
module tpm_group_file #(
   parameter int NUM_PORTS = 13,
   parameter int GID_W     = 3,
   parameter int ADDR_W    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [GID_W-1:0]     wr_gid,
   input  logic [ADDR_W-1:0]    src_port,
   output logic [GID_W-1:0]     src_gid,
   output logic [NUM_PORTS-1:0] excl_vec
);
   if ((1 << ADDR_W) < NUM_PORTS) begin : g_bad_addr
      $error("tpm_group_file: address too narrow for port count");
   end

   logic [NUM_PORTS-1:0][GID_W-1:0] gid_q;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            gid_q[p] <= '0;
         end else if (wr_en && (wr_addr == ADDR_W'(p))) begin
            gid_q[p] <= wr_gid;
         end
      end
   end

   // Ingress group lookup; numbers past the last port read as group 0
   always_comb begin
      src_gid = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (src_port == ADDR_W'(p)) src_gid = gid_q[p];
      end
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_excl
      assign excl_vec[p] = (src_gid != '0) && (gid_q[p] == src_gid);
   end

   // R8
   gid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(gid_q))
      else $error("group file changed without a write");

endmodule

// File: rtl/trunk_port_masker.sv
module trunk_port_masker #(
   parameter int NUM_PORTS = 13,
   parameter int KEY_W     = 3,
   parameter int GID_W     = 3,
   parameter int MAC_W     = 48,
   parameter int HASH_MODE = 0,
   localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic                 cfg_target,
   input  logic [PORT_W-1:0]    cfg_addr,
   input  logic [NUM_PORTS-1:0] cfg_wdata,
   input  logic                 move_chk_en,
   input  logic                 in_valid,
   input  logic [PORT_W-1:0]    in_src_port,
   input  logic [NUM_PORTS-1:0] in_vlan_mask,
   input  logic [MAC_W-1:0]     in_dst_mac,
   input  logic [MAC_W-1:0]     in_src_mac,
   input  logic [GID_W-1:0]     in_learned_gid,
   output logic                 out_valid,
   output logic [NUM_PORTS-1:0] out_mask,
   output logic                 out_moved
);
   import trunk_pkg::*;

   if (NUM_PORTS < 2 || NUM_PORTS > 64) begin : g_bad_ports
      $error("trunk_port_masker: NUM_PORTS out of range");
   end
   if (GID_W < 1 || GID_W > NUM_PORTS) begin : g_bad_gid
      $error("trunk_port_masker: GID_W must fit in the write data");
   end
   if (PORT_W < KEY_W) begin : g_bad_key
      $error("trunk_port_masker: KEY_W wider than the config address");
   end

   cfg_target_e cfg_tgt;
   assign cfg_tgt = cfg_target_e'(cfg_target);

   logic mask_we, gid_we;
   assign mask_we = cfg_we && (cfg_tgt == CFG_FWD_MASK);
   assign gid_we  = cfg_we && (cfg_tgt == CFG_GROUP_ID);

   logic [KEY_W-1:0]     hash_key;
   logic [NUM_PORTS-1:0] sel_mask;
   logic [GID_W-1:0]     src_gid;
   logic [NUM_PORTS-1:0] excl_vec;

   tpm_hash #(
      .MAC_W     (MAC_W),
      .KEY_W     (KEY_W),
      .HASH_MODE (HASH_MODE)
   ) u_hash (
      .dst_mac (in_dst_mac),
      .src_mac (in_src_mac),
      .key     (hash_key)
   );

   tpm_mask_bank #(
      .NUM_PORTS (NUM_PORTS),
      .KEY_W     (KEY_W),
      .ADDR_W    (PORT_W)
   ) u_mask_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (mask_we),
      .wr_addr (cfg_addr),
      .wr_data (cfg_wdata),
      .rd_key  (hash_key),
      .rd_mask (sel_mask)
   );

   tpm_group_file #(
      .NUM_PORTS (NUM_PORTS),
      .GID_W     (GID_W),
      .ADDR_W    (PORT_W)
   ) u_group_file (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (gid_we),
      .wr_addr  (cfg_addr),
      .wr_gid   (cfg_wdata[GID_W-1:0]),
      .src_port (in_src_port),
      .src_gid  (src_gid),
      .excl_vec (excl_vec)
   );

   logic [NUM_PORTS-1:0] mask_d;
   logic                 moved_d;

   assign mask_d  = in_vlan_mask & sel_mask & ~excl_vec;
   assign moved_d = move_chk_en && (in_learned_gid != src_gid);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_mask  <= '0;
         out_moved <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_mask  <= mask_d;
            out_moved <= moved_d;
         end
      end
   end

   // R6
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid)
      else $error("result strobe missing");

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_mask) && $stable(out_moved)))
      else $error("outputs moved while idle");

   // R3
   vlan_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ((out_mask & ~$past(in_vlan_mask)) == '0))
      else $error("egress port outside VLAN membership");

   // R5
   move_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !move_chk_en) |=> !out_moved)
      else $error("move flag raised while check disabled");

endmodule

// File: tb/test_trunk_port_masker.sv
`timescale 1ns/1ps
module test_trunk_port_masker;

   localparam int NP = 13;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic          cfg_target = 1'b0;
   logic [3:0]    cfg_addr = '0;
   logic [NP-1:0] cfg_wdata = '0;
   logic          move_chk_en = 1'b0;
   logic          in_valid = 1'b0;
   logic [3:0]    in_src_port = '0;
   logic [NP-1:0] in_vlan_mask = '0;
   logic [47:0]   in_dst_mac = '0;
   logic [47:0]   in_src_mac = '0;
   logic [2:0]    in_learned_gid = '0;
   logic          out_valid;
   logic [NP-1:0] out_mask;
   logic          out_moved;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   trunk_port_masker i_trunk_port_masker (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_target(cfg_target),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .move_chk_en(move_chk_en),
      .in_valid(in_valid), .in_src_port(in_src_port), .in_vlan_mask(in_vlan_mask),
      .in_dst_mac(in_dst_mac), .in_src_mac(in_src_mac),
      .in_learned_gid(in_learned_gid), .out_valid(out_valid),
      .out_mask(out_mask), .out_moved(out_moved)
   );

   // Bench mirror of the configured state, kept from the requirements
   logic [NP-1:0] mdl_mask [8];
   logic [2:0]    mdl_gid  [NP];

   // Vector fields: src(4) vlan(13) da(3) sa(3) learned(3) en(1)
   localparam int VW = 27;
   localparam logic [VW-1:0] VEC [8] = '{
      {4'd0,  13'h1fff, 3'd0, 3'd0, 3'd0, 1'b1},
      {4'd2,  13'h1fff, 3'd1, 3'd0, 3'd1, 1'b1},
      {4'd5,  13'h1fff, 3'd3, 3'd1, 3'd1, 1'b1},
      {4'd5,  13'h1fff, 3'd3, 3'd1, 3'd1, 1'b0},
      {4'd12, 13'h0f0f, 3'd5, 3'd2, 3'd0, 1'b1},
      {4'd14, 13'h1fff, 3'd6, 3'd6, 3'd2, 1'b1},
      {4'd3,  13'h00ff, 3'd7, 3'd3, 3'd1, 1'b0},
      {4'd7,  13'h1000, 3'd2, 3'd0, 3'd2, 1'b1}
   };

   function automatic logic [2:0] gid_of(input logic [3:0] src);
      return (src < NP) ? mdl_gid[src] : 3'd0;
   endfunction

   function automatic logic [NP-1:0] exp_mask(input logic [3:0] src,
         input logic [NP-1:0] vlan, input logic [2:0] da, input logic [2:0] sa);
      logic [NP-1:0] r;
      logic [2:0] g;
      g = gid_of(src);
      r = vlan & mdl_mask[da ^ sa];
      for (int p = 0; p < NP; p++) begin
         if (g != 3'd0 && mdl_gid[p] == g) r[p] = 1'b0;
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [NP-1:0] act, input logic [NP-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic cfg_write(input logic tgt, input logic [3:0] addr,
                            input logic [NP-1:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_target = tgt; cfg_addr = addr; cfg_wdata = data;
      @(negedge clk);
      cfg_we = 1'b0;
      if (tgt == 1'b0 && addr < 8) mdl_mask[addr] = data;
      if (tgt == 1'b1 && addr < NP) mdl_gid[addr] = data[2:0];
   endtask

   task automatic drive_frame(input logic [3:0] src, input logic [NP-1:0] vlan,
         input logic [2:0] da, input logic [2:0] sa, input logic [2:0] lg,
         input logic en);
      in_valid = 1'b1; in_src_port = src; in_vlan_mask = vlan;
      in_dst_mac = {45'h0a5c3f12e9b7, da}; in_src_mac = {45'h17d2c08e4a61, sa};
      in_learned_gid = lg; move_chk_en = en;
   endtask

   task automatic frame_check(input string req, input logic [3:0] src,
         input logic [NP-1:0] vlan, input logic [2:0] da, input logic [2:0] sa,
         input logic [2:0] lg, input logic en);
      logic [NP-1:0] em;
      logic emv;
      em  = exp_mask(src, vlan, da, sa);
      emv = en && (lg != gid_of(src));
      @(negedge clk);
      drive_frame(src, vlan, da, sa, lg, en);
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b1, "R6", "out_valid", NP'(out_valid), NP'(1));
      check(out_mask == em, req, "out_mask", out_mask, em);
      check(out_moved == emv, "R5", "out_moved", NP'(out_moved), NP'(emv));
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [NP-1:0] held;
      logic [NP-1:0] old_m;
      logic [NP-1:0] new_m;
      for (int k = 0; k < 8; k++) mdl_mask[k] = '1;
      for (int p = 0; p < NP; p++) mdl_gid[p] = 3'd0;
      repeat (3) @(negedge clk);
      // R1: reset values at the outputs
      check(out_valid == 1'b0, "R1", "reset out_valid", NP'(out_valid), '0);
      check(out_mask == '0, "R1", "reset out_mask", out_mask, '0);
      check(out_moved == 1'b0, "R1", "reset out_moved", NP'(out_moved), '0);
      rst_n = 1'b1;
      // R1: unconfigured masks pass the VLAN mask through
      frame_check("R1", 4'd4, 13'h1abc, 3'd5, 3'd1, 3'd0, 1'b1);

      // Configure groups: ports 2,3 in group 1; ports 5,6,7 in group 2
      cfg_write(1'b1, 4'd2, NP'(1));
      cfg_write(1'b1, 4'd3, NP'(1));
      cfg_write(1'b1, 4'd5, NP'(2));
      cfg_write(1'b1, 4'd6, NP'(2));
      cfg_write(1'b1, 4'd7, NP'(2));
      // One member of each group open per key (R7)
      for (int k = 0; k < 8; k++) begin
         logic [NP-1:0] m;
         m = '1;
         m[3:2] = 2'b00; m[7:5] = 3'b000;
         m[(k % 2 == 1) ? 3 : 2] = 1'b1;
         m[5 + (k % 3)] = 1'b1;
         cfg_write(1'b0, 4'(k), m);
      end

      // R2 R3 R4 R5 R10: table of frames
      for (int v = 0; v < 8; v++) begin
         logic [VW-1:0] e;
         e = VEC[v];
         frame_check((v == 5) ? "R10" : (v == 1 || v == 2 || v == 7) ? "R4" : "R3",
                     e[26:23], e[22:10], e[9:7], e[6:4], e[3:1], e[0]);
      end
      // R2: every key selects its own entry
      for (int k = 0; k < 8; k++) begin
         frame_check("R2", 4'd0, 13'h1fff, 3'(k), 3'd0, 3'd0, 1'b0);
      end

      // R6: outputs hold while idle
      held = out_mask;
      @(negedge clk);
      check(out_valid == 1'b0, "R6", "idle out_valid", NP'(out_valid), '0);
      check(out_mask == held, "R6", "idle out_mask", out_mask, held);

      // R7: out-of-range mask address changes nothing
      cfg_write(1'b0, 4'd9, 13'h0000);
      for (int k = 0; k < 8; k++) begin
         frame_check("R7", 4'd1, 13'h1fff, 3'(k), 3'd0, 3'd0, 1'b0);
      end
      // R8: out-of-range group address changes nothing
      cfg_write(1'b1, 4'd14, NP'(1));
      frame_check("R8", 4'd2, 13'h1fff, 3'd4, 3'd0, 3'd1, 1'b1);
      frame_check("R8", 4'd0, 13'h1fff, 3'd4, 3'd0, 3'd0, 1'b1);

      // R9: mask write collides with a frame using that entry
      old_m = mdl_mask[3];
      new_m = 13'h0a5a;
      @(negedge clk);
      cfg_we = 1'b1; cfg_target = 1'b0; cfg_addr = 4'd3; cfg_wdata = new_m;
      drive_frame(4'd0, 13'h1fff, 3'd3, 3'd0, 3'd0, 1'b0);
      @(negedge clk);
      cfg_we = 1'b0; in_valid = 1'b0;
      check(out_mask == (13'h1fff & old_m), "R9", "collision uses old mask",
            out_mask, 13'h1fff & old_m);
      mdl_mask[3] = new_m;
      frame_check("R9", 4'd0, 13'h1fff, 3'd3, 3'd0, 3'd0, 1'b0);

      // R9: group write collides with a frame from that port
      @(negedge clk);
      cfg_we = 1'b1; cfg_target = 1'b1; cfg_addr = 4'd9; cfg_wdata = NP'(2);
      drive_frame(4'd9, 13'h1fff, 3'd0, 3'd0, 3'd2, 1'b1);
      @(negedge clk);
      cfg_we = 1'b0; in_valid = 1'b0;
      check(out_moved == 1'b1, "R9", "collision move flag", NP'(out_moved), NP'(1));
      check(out_mask == (13'h1fff & mdl_mask[0]), "R9", "collision exclusion",
            out_mask, 13'h1fff & mdl_mask[0]);
      mdl_gid[9] = 3'd2;
      frame_check("R9", 4'd9, 13'h1fff, 3'd0, 3'd0, 3'd2, 1'b1);

      finish_run();
   end

endmodule